// File: doc/BRIEF.md
# USB Host Control Transfer Sequencer

This block drives the three stages of a host-side control transfer on endpoint 0. Software (or a higher-level controller) hands it one start command carrying the request kind and the number of bytes in the data stage. The sequencer then asks a lower-level transaction engine for one transaction at a time: first the SETUP, then zero or more data packets, then the status handshake. The status stage always runs in the opposite direction to the data stage, or runs IN when there is no data stage.

After each transaction the engine returns a handshake code. ACK moves the transfer forward. NAK repeats the same transaction. STALL or a transfer error ends the transfer. Repeated NAKs are bounded by elapsed frames, not by attempts: a counter of start-of-frame ticks runs from the last non-NAK handshake. Once it reaches a programmable limit, the transfer ends with a timeout.

Completion is marked by a one-cycle done pulse together with a status code that stays valid until the next completion.

Top module: `usb_ctrl_xfer_seq`

## Requirements
- R1: Kind 0 (zero-data; kind 3 behaves the same) issues SETUP (pid code 0, toggle 0, length 8) followed directly by an IN status transaction (pid code 2, toggle 1, length 0).
- R2: Kind 1 (write) issues SETUP, then OUT data transactions (pid code 1), then an IN status transaction with toggle 1 and length 0.
- R3: Kind 2 (read) issues SETUP, then IN data transactions, then an OUT status transaction with toggle 1 and length 0.
- R4: The data stage is cut into packets of MAX_PKT bytes, with a shorter last packet when the length is not a multiple. The first data packet uses toggle 1 and each following packet flips it.
- R5: On handshake code 1 (NAK) the same transaction is requested again on the next cycle, with identical pid, toggle and length.
- R6: A frame counter is cleared at start and on every non-NAK handshake, and it counts sof_i ticks. When a NAK arrives while the counter is at least nak_limit_i and nak_limit_i is 2 or more, the transfer ends with status 3 (timeout).
- R7: A nak_limit_i of 0 or 1 disables the timeout, so NAKs are retried without bound.
- R8: Handshake code 2 (STALL) on any stage ends the transfer with status 1 and no further transaction.
- R9: Handshake code 3 (error) ends the transfer with status 2 and no further transaction.
- R10: A start while busy_o is high is ignored. Completion raises done_o for exactly one cycle, and a successful transfer reports status 0.
- R11: After reset, busy_o, done_o and txn_req_o are low. A reset in the middle of a transfer returns the block to idle.
- R12: A write or read with data length 0 skips the data stage and goes straight to the status stage in that kind's status direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transfer (taken only when idle) |
| kind_i | input | 2 | Request kind: 0 zero-data, 1 write, 2 read, 3 as zero-data |
| data_len_i | input | LEN_W | Data stage byte count |
| nak_limit_i | input | NAK_W | NAK timeout in frames; 0 or 1 disables |
| sof_i | input | 1 | Start-of-frame tick |
| txn_req_o | output | 1 | One-cycle request for a transaction |
| txn_pid_o | output | 2 | Token: 0 SETUP, 1 OUT, 2 IN |
| txn_toggle_o | output | 1 | Data toggle (0 DATA0, 1 DATA1) |
| txn_len_o | output | LEN_W | Bytes in this transaction |
| txn_done_i | input | 1 | Engine finished the transaction |
| txn_hs_i | input | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL, 3 error |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 stall, 2 error, 3 NAK timeout |

## Verification
The bench builds the block with MAX_PKT set to 8 and keeps the default 16-bit length and limit widths. With packets this small, byte counts of 5 to 20 produce several data packets. That exercises toggle alternation, a short final packet and an exact multiple of the packet size, without long runs. NAK limits of 0, 1 and 3 are reachable in a few frames, so the bench covers both the unbounded retry case and a counter that is cleared by an ACK before it expires.

// File: rtl/usb_ctrl_pkg.sv
package usb_ctrl_pkg;
  typedef enum logic [1:0] {KIND_ZERO, KIND_WRITE, KIND_READ, KIND_RSVD} req_kind_e;
  typedef enum logic [1:0] {PID_SETUP, PID_OUT, PID_IN, PID_NONE} pid_e;
  typedef enum logic [1:0] {HS_ACK, HS_NAK, HS_STALL, HS_ERR} hs_e;
  typedef enum logic [1:0] {ST_OK, ST_STALL, ST_ERROR, ST_TIMEOUT} xfer_status_e;
  typedef enum logic [1:0] {STG_IDLE, STG_SETUP, STG_DATA, STG_STATUS} stage_e;
  localparam int unsigned SETUP_BYTES = 8;
endpackage

// File: rtl/usb_ctrl_data_track.sv
module usb_ctrl_data_track #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_PKT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             adv_i,
  output logic [LEN_W-1:0] chunk_o,
  output logic             last_o,
  output logic             empty_o,
  output logic             tog_o
);
  localparam logic [LEN_W-1:0] MPS = LEN_W'(MAX_PKT);

  logic [LEN_W-1:0] rem_q, rem_d;
  logic             tog_q, tog_d;
  logic             en;

  assign chunk_o = (rem_q > MPS) ? MPS : rem_q;
  assign last_o  = (rem_q <= MPS);
  assign empty_o = (rem_q == '0);
  assign tog_o   = tog_q;
  assign en      = load_i | adv_i;

  always_comb begin
    rem_d = rem_q;
    tog_d = tog_q;
    if (load_i) begin
      rem_d = len_i;
      tog_d = 1'b1;
    end else if (adv_i) begin
      rem_d = rem_q - chunk_o;
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      tog_q <= 1'b1;
    end else if (en) begin
      rem_q <= rem_d;
      tog_q <= tog_d;
    end
  end
endmodule

// File: rtl/usb_ctrl_nak_timer.sv
module usb_ctrl_nak_timer #(
  parameter int unsigned NAK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             sof_i,
  input  logic [NAK_W-1:0] limit_i,
  output logic             expired_o
);
  localparam logic [NAK_W-1:0] CNT_MAX = '1;
  localparam logic [NAK_W-1:0] LIM_MIN = NAK_W'(2);

  logic [NAK_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign en        = clr_i | (run_i & sof_i & (cnt_q != CNT_MAX));
  assign cnt_d     = clr_i ? '0 : cnt_q + 1'b1;
  assign expired_o = (limit_i >= LIM_MIN) && (cnt_q >= limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/usb_ctrl_stage_fsm.sv
module usb_ctrl_stage_fsm
  import usb_ctrl_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic             txn_done_i,
  input  logic [1:0]       txn_hs_i,
  input  logic [LEN_W-1:0] chunk_i,
  input  logic             last_i,
  input  logic             empty_i,
  input  logic             tog_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             clr_o,
  output logic             txn_req_o,
  output logic [1:0]       txn_pid_o,
  output logic             txn_toggle_o,
  output logic [LEN_W-1:0] txn_len_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o
);
  stage_e       stage_q, stage_d;
  req_kind_e    kind_q, kind_d;
  xfer_status_e status_q, status_d;
  logic         issue_q, issue_d;
  logic         done_q, done_d;
  logic         accept, hs_in;

  assign accept = (stage_q == STG_IDLE) && start_i;
  assign hs_in  = (stage_q != STG_IDLE) && txn_done_i;
  assign load_o = accept;
  assign adv_o  = hs_in && (stage_q == STG_DATA) && (txn_hs_i == HS_ACK);
  assign clr_o  = accept || (hs_in && (txn_hs_i != HS_NAK));

  always_comb begin
    stage_d  = stage_q;
    kind_d   = kind_q;
    status_d = status_q;
    issue_d  = 1'b0;
    done_d   = 1'b0;
    if (accept) begin
      stage_d = STG_SETUP;
      issue_d = 1'b1;
      kind_d  = (kind_i == KIND_RSVD) ? KIND_ZERO : req_kind_e'(kind_i);
    end else if (hs_in) begin
      unique case (hs_e'(txn_hs_i))
        HS_ACK: begin
          issue_d = 1'b1;
          unique case (stage_q)
            STG_SETUP:  stage_d = (kind_q == KIND_ZERO || empty_i) ? STG_STATUS : STG_DATA;
            STG_DATA:   if (last_i) stage_d = STG_STATUS;
            default: begin
              stage_d  = STG_IDLE;
              issue_d  = 1'b0;
              done_d   = 1'b1;
              status_d = ST_OK;
            end
          endcase
        end
        HS_NAK: begin
          if (expired_i) begin
            stage_d  = STG_IDLE;
            done_d   = 1'b1;
            status_d = ST_TIMEOUT;
          end else begin
            issue_d = 1'b1;
          end
        end
        HS_STALL: begin
          stage_d  = STG_IDLE;
          done_d   = 1'b1;
          status_d = ST_STALL;
        end
        default: begin
          stage_d  = STG_IDLE;
          done_d   = 1'b1;
          status_d = ST_ERROR;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= STG_IDLE;
      kind_q   <= KIND_ZERO;
      status_q <= ST_OK;
      issue_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      kind_q   <= kind_d;
      status_q <= status_d;
      issue_q  <= issue_d;
      done_q   <= done_d;
    end
  end

  always_comb begin
    unique case (stage_q)
      STG_SETUP: begin
        txn_pid_o    = PID_SETUP;
        txn_toggle_o = 1'b0;
        txn_len_o    = LEN_W'(SETUP_BYTES);
      end
      STG_DATA: begin
        txn_pid_o    = (kind_q == KIND_WRITE) ? PID_OUT : PID_IN;
        txn_toggle_o = tog_i;
        txn_len_o    = chunk_i;
      end
      STG_STATUS: begin
        txn_pid_o    = (kind_q == KIND_READ) ? PID_OUT : PID_IN;
        txn_toggle_o = 1'b1;
        txn_len_o    = '0;
      end
      default: begin
        txn_pid_o    = PID_NONE;
        txn_toggle_o = 1'b0;
        txn_len_o    = '0;
      end
    endcase
  end

  assign txn_req_o = issue_q;
  assign busy_o    = (stage_q != STG_IDLE);
  assign done_o    = done_q;
  assign status_o  = status_q;
endmodule

// File: rtl/usb_ctrl_xfer_seq.sv
module usb_ctrl_xfer_seq #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned NAK_W   = 16,
  parameter int unsigned MAX_PKT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic [LEN_W-1:0] data_len_i,
  input  logic [NAK_W-1:0] nak_limit_i,
  input  logic             sof_i,
  output logic             txn_req_o,
  output logic [1:0]       txn_pid_o,
  output logic             txn_toggle_o,
  output logic [LEN_W-1:0] txn_len_o,
  input  logic             txn_done_i,
  input  logic [1:0]       txn_hs_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o
);
  logic             load, adv, clr, last, empty, tog, expired;
  logic [LEN_W-1:0] chunk;

  usb_ctrl_data_track #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) data_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .len_i(data_len_i), .adv_i(adv),
    .chunk_o(chunk), .last_o(last), .empty_o(empty), .tog_o(tog)
  );

  usb_ctrl_nak_timer #(.NAK_W(NAK_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .run_i(busy_o), .sof_i(sof_i),
    .limit_i(nak_limit_i), .expired_o(expired)
  );

  usb_ctrl_stage_fsm #(.LEN_W(LEN_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .txn_done_i(txn_done_i), .txn_hs_i(txn_hs_i), .chunk_i(chunk),
    .last_i(last), .empty_i(empty), .tog_i(tog), .expired_i(expired),
    .load_o(load), .adv_o(adv), .clr_o(clr), .txn_req_o(txn_req_o),
    .txn_pid_o(txn_pid_o), .txn_toggle_o(txn_toggle_o), .txn_len_o(txn_len_o),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );
endmodule

// File: rtl/usb_ctrl_xfer_seq_chk.sv
module usb_ctrl_xfer_seq_chk
  import usb_ctrl_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_PKT = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             txn_req_o,
  input logic [1:0]       txn_pid_o,
  input logic             txn_toggle_o,
  input logic [LEN_W-1:0] txn_len_o,
  input logic             txn_done_i,
  input logic [1:0]       txn_hs_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       status_o
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req_o |-> busy_o);

  a_r1_setup_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req_o && txn_pid_o == PID_SETUP) |-> (!txn_toggle_o && txn_len_o == LEN_W'(SETUP_BYTES)));

  a_r4_pkt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req_o && txn_pid_o != PID_SETUP) |-> (txn_len_o <= LEN_W'(MAX_PKT)));

  a_r5_nak_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && txn_done_i && txn_hs_i == HS_NAK) |=>
      ((txn_req_o && $stable(txn_pid_o) && $stable(txn_toggle_o) && $stable(txn_len_o))
       || (done_o && status_o == ST_TIMEOUT)));

  a_r8_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && txn_done_i && txn_hs_i == HS_STALL) |=> (done_o && !busy_o && status_o == ST_STALL));

  a_r9_error_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && txn_done_i && txn_hs_i == HS_ERR) |=> (done_o && !busy_o && status_o == ST_ERROR));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !txn_done_i) |=> (busy_o && !done_o));
endmodule

bind usb_ctrl_xfer_seq usb_ctrl_xfer_seq_chk #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .txn_req_o(txn_req_o),
  .txn_pid_o(txn_pid_o), .txn_toggle_o(txn_toggle_o), .txn_len_o(txn_len_o),
  .txn_done_i(txn_done_i), .txn_hs_i(txn_hs_i), .busy_o(busy_o),
  .done_o(done_o), .status_o(status_o)
);

// File: tb/usb_ctrl_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module usb_ctrl_xfer_seq_tb_top;
  localparam int unsigned LEN_W = 16;
  localparam int unsigned NAK_W = 16;
  localparam int unsigned MPKT  = 8;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] len;
    logic [3:0]  naks;
    logic [7:0]  stall_at;
    logic [7:0]  err_at;
    logic [15:0] nlim;
    logic [1:0]  st;
    logic        poke;
    logic [3:0]  rid;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd0,  4'd0, 8'hFF, 8'hFF, 16'd0, 2'd0, 1'b0, 4'd1},   // R1 zero-data
    '{2'd1, 16'd20, 4'd0, 8'hFF, 8'hFF, 16'd0, 2'd0, 1'b0, 4'd2},   // R2 write, 8+8+4
    '{2'd2, 16'd16, 4'd0, 8'hFF, 8'hFF, 16'd0, 2'd0, 1'b0, 4'd4},   // R4 read, exact multiple
    '{2'd2, 16'd5,  4'd2, 8'hFF, 8'hFF, 16'd3, 2'd0, 1'b0, 4'd5},   // R5 retries, R6 counter cleared by ACK
    '{2'd1, 16'd3,  4'd3, 8'hFF, 8'hFF, 16'd3, 2'd3, 1'b0, 4'd6},   // R6 timeout
    '{2'd0, 16'd0,  4'd4, 8'hFF, 8'hFF, 16'd0, 2'd0, 1'b0, 4'd7},   // R7 limit 0
    '{2'd0, 16'd0,  4'd4, 8'hFF, 8'hFF, 16'd1, 2'd0, 1'b0, 4'd7},   // R7 limit 1
    '{2'd1, 16'd12, 4'd0, 8'd2,  8'hFF, 16'd0, 2'd1, 1'b0, 4'd8},   // R8 stall on second OUT
    '{2'd2, 16'd8,  4'd0, 8'hFF, 8'd0,  16'd0, 2'd2, 1'b0, 4'd9},   // R9 error on SETUP
    '{2'd1, 16'd0,  4'd0, 8'hFF, 8'hFF, 16'd0, 2'd0, 1'b0, 4'd12},  // R12 write no data
    '{2'd2, 16'd0,  4'd0, 8'hFF, 8'hFF, 16'd0, 2'd0, 1'b0, 4'd12},  // R12 read no data
    '{2'd1, 16'd9,  4'd0, 8'hFF, 8'hFF, 16'd0, 2'd0, 1'b1, 4'd10},  // R10 start while busy
    '{2'd3, 16'd4,  4'd0, 8'hFF, 8'hFF, 16'd0, 2'd0, 1'b0, 4'd3}    // R3 id reused: kind 3 as zero-data (R1)
  };

  logic             clk, rst_n, start_i, sof_i, txn_done_i;
  logic [1:0]       kind_i, txn_hs_i;
  logic [LEN_W-1:0] data_len_i;
  logic [NAK_W-1:0] nak_limit_i;
  logic             txn_req_o, txn_toggle_o, busy_o, done_o;
  logic [1:0]       txn_pid_o, status_o;
  logic [LEN_W-1:0] txn_len_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  usb_ctrl_xfer_seq #(.LEN_W(LEN_W), .NAK_W(NAK_W), .MAX_PKT(MPKT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .data_len_i(data_len_i), .nak_limit_i(nak_limit_i), .sof_i(sof_i),
    .txn_req_o(txn_req_o), .txn_pid_o(txn_pid_o), .txn_toggle_o(txn_toggle_o),
    .txn_len_o(txn_len_o), .txn_done_i(txn_done_i), .txn_hs_i(txn_hs_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL R11 watchdog expired: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int  e_pid [64];
    int  e_tog [64];
    int  e_len [64];
    int  n = 0;
    int  eff, rem, tog, idx, nak_given, guard;
    bit  finished, poked;
    string rq;
    rq  = $sformatf("R%0d", v.rid);
    eff = (v.kind == 2'd3) ? 0 : int'(v.kind);
    e_pid[0] = 0; e_tog[0] = 0; e_len[0] = 8; n = 1;
    if (eff != 0) begin
      rem = int'(v.len); tog = 1;
      while (rem > 0) begin
        e_pid[n] = (eff == 1) ? 1 : 2;
        e_tog[n] = tog;
        e_len[n] = (rem > int'(MPKT)) ? int'(MPKT) : rem;
        rem = rem - e_len[n];
        tog = 1 - tog;
        n++;
      end
    end
    e_pid[n] = (eff == 2) ? 1 : 2; e_tog[n] = 1; e_len[n] = 0; n++;

    nak_limit_i = v.nlim;
    @(negedge clk);
    start_i = 1'b1; kind_i = v.kind; data_len_i = v.len;
    @(negedge clk);
    start_i = 1'b0;
    idx = 0; nak_given = 0; finished = 0; poked = 0; guard = 0;
    while (!finished && guard < 5000) begin
      guard++;
      if (done_o) begin
        chk(status_o == v.st, rq, "final status", int'(status_o), int'(v.st));
        if (v.st == 2'd0)      chk(idx == n, rq, "transactions completed", idx, n);
        else if (v.st == 2'd1) chk(idx == int'(v.stall_at), rq, "stopped at stall", idx, int'(v.stall_at));
        else if (v.st == 2'd2) chk(idx == int'(v.err_at), rq, "stopped at error", idx, int'(v.err_at));
        else                   chk(nak_given == int'(v.nlim), rq, "NAKs before timeout", nak_given, int'(v.nlim));
        @(negedge clk);
        chk(!done_o && !busy_o, "R10", "done pulse width / idle after", int'({done_o, busy_o}), 0);
        finished = 1;
      end else if (txn_req_o) begin
        if (idx < n) begin
          chk(int'(txn_pid_o) == e_pid[idx], rq, "pid", int'(txn_pid_o), e_pid[idx]);
          chk(int'(txn_toggle_o) == e_tog[idx], "R4", "toggle", int'(txn_toggle_o), e_tog[idx]);
          chk(int'(txn_len_o) == e_len[idx], "R4", "length", int'(txn_len_o), e_len[idx]);
        end else begin
          chk(1'b0, rq, "extra transaction", idx, n);
        end
        @(negedge clk);
        if (v.poke && !poked) begin
          start_i = 1'b1; kind_i = 2'd2; data_len_i = 16'd30;
          @(negedge clk);
          start_i = 1'b0;
          poked = 1;
        end
        if (idx == int'(v.stall_at))    txn_hs_i = 2'd2;
        else if (idx == int'(v.err_at)) txn_hs_i = 2'd3;
        else if (nak_given < int'(v.naks)) begin
          sof_i = 1'b1;
          @(negedge clk);
          sof_i = 1'b0;
          txn_hs_i = 2'd1;
        end else txn_hs_i = 2'd0;
        txn_done_i = 1'b1;
        @(negedge clk);
        txn_done_i = 1'b0;
        if (txn_hs_i == 2'd1) nak_given++;
        else if (txn_hs_i == 2'd0) begin idx++; nak_given = 0; end
      end else begin
        @(negedge clk);
      end
    end
    if (!finished) chk(1'b0, rq, "transfer never completed", 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; sof_i = 1'b0; txn_done_i = 1'b0;
    kind_i = 2'd0; txn_hs_i = 2'd0; data_len_i = '0; nak_limit_i = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy_o && !done_o && !txn_req_o, "R11", "reset outputs", int'({busy_o, done_o, txn_req_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !txn_req_o, "R11", "idle after release", int'({busy_o, txn_req_o}), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11 reset in the middle of a write transfer
    @(negedge clk);
    start_i = 1'b1; kind_i = 2'd1; data_len_i = 16'd20; nak_limit_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && txn_req_o, "R11", "transfer started", int'({busy_o, txn_req_o}), 3);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && !txn_req_o && !done_o, "R11", "reset mid transfer", int'({busy_o, txn_req_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(VECS[1]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule